// File: doc/BRIEF.md
# Four-Line Translation Cache with Rank Replacement

This block is a small fully associative cache of address translations. Each of its four lines holds a valid flag, a 2-bit recency rank, a 19-bit tag and a 19-bit frame start address. The tag is the combined segment and page number of a virtual address. A lookup presents a 28-bit virtual address. One cycle later the block reports whether the tag was found. On a hit it also returns the physical address, which is the stored frame start plus the 9-bit word offset.

When a lookup misses, the surrounding logic walks the segment and page tables. If that walk produces a frame, the frame and the tag are written through the fill port. The line with rank 0 (the least recently used one) is replaced. If the walk ends in a fault or an error, nothing is written and the cache keeps its previous contents. Recency is kept as explicit per-line ranks. Together the four ranks always form a permutation of 0..3, with 3 meaning most recent.

Top module: `xlat_cache`

## Requirements
- R1: During and right after a synchronous active-high reset, `res_valid` and `res_hit` are low. Every line is invalid, so any lookup made before the first fill misses.
- R2: A lookup with `lk_valid` high produces exactly one cycle with `res_valid` high, on the next cycle. A cycle without a lookup, including a fill cycle, produces `res_valid` low on the next cycle.
- R3: A lookup hits when `lk_vaddr[27:9]` equals the tag of a valid line. `res_paddr` is then that line's frame plus `lk_vaddr[8:0]`, taken modulo 2^19.
- R4: On a miss, `res_hit` is 0 and `res_paddr` is 0. The ranks, tags and frames do not change.
- R5: A fill writes its tag and frame into the line whose rank is 0 and marks that line valid. That line's rank becomes 3, and every other rank drops by 1.
- R6: On a hit in line k, every line with a rank greater than rank[k] drops by 1, and rank[k] becomes 3.
- R7: The four ranks always form a permutation of 0..3. The line that the next fill replaces is therefore always unique.
- R8: A lookup and a fill are never presented in the same cycle. A fill is only issued after the walk that followed a miss.
- R9: Reset gives line i the rank i. The first four fills after reset therefore go to lines 0, 1, 2 and 3, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 28 | Virtual address: tag in [27:9], offset in [8:0] |
| fill_valid | input | 1 | Write a translation after a successful walk |
| fill_tag | input | 19 | Segment-page tag to install |
| fill_frame | input | 19 | Frame start address to install |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| res_paddr | output | 19 | Physical address on a hit, 0 on a miss |

## Verification
The bench builds the block with its default parameters: four lines, a 19-bit tag, a 9-bit offset and a 19-bit frame. With those values, frames near the top of the address space make the offset addition wrap modulo 2^19. Four lines are also few enough that a short run of hits followed by fills reaches every rank permutation that decides the victim. A behavioural model tracks ranks, tags and frames and predicts each outcome. A long pseudo-random stretch then draws from a small tag pool that is larger than the cache, which forces steady eviction and re-hits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_HIT  = 2'd1,
    UPD_FILL = 2'd2
  } upd_e;
endpackage

// File: rtl/xlat_line.sv
module xlat_line
  import xlat_pkg::*;
#(
  parameter int TAG_W     = 19,
  parameter int FRAME_W   = 19,
  parameter int RANK_W    = 2,
  parameter int INIT_RANK = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  upd_e               upd,
  input  logic               chosen,
  input  logic [RANK_W-1:0]  ref_rank,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               match,
  output logic [FRAME_W-1:0] frame,
  output logic [RANK_W-1:0]  rank,
  output logic               valid
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      tag_q <= '0;
      frame <= '0;
      rank  <= RANK_W'(INIT_RANK);
    end else if (upd != UPD_NONE) begin
      if (chosen) begin
        rank <= '1;
        if (upd == UPD_FILL) begin
          valid <= 1'b1;
          tag_q <= fill_tag;
          frame <= fill_frame;
        end
      end else if (rank > ref_rank) begin
        rank <= rank - 1'b1;
      end
    end
  end

  assign match = valid && (tag_q == look_tag);
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int LINES   = 4,
  parameter int RANK_W  = 2,
  parameter int FRAME_W = 19
) (
  input  logic [LINES-1:0]         match,
  input  logic [LINES*RANK_W-1:0]  rank_flat,
  input  logic [LINES*FRAME_W-1:0] frame_flat,
  output logic                     any_hit,
  output logic [RANK_W-1:0]        hit_rank,
  output logic [FRAME_W-1:0]       hit_frame,
  output logic [LINES-1:0]         victim
);
  always_comb begin
    any_hit   = |match;
    hit_rank  = '0;
    hit_frame = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) begin
        hit_rank  = hit_rank  | rank_flat[i*RANK_W +: RANK_W];
        hit_frame = hit_frame | frame_flat[i*FRAME_W +: FRAME_W];
      end
      victim[i] = (rank_flat[i*RANK_W +: RANK_W] == '0);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int LINES   = 4,
  parameter int TAG_W   = 19,
  parameter int OFF_W   = 9,
  parameter int FRAME_W = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [TAG_W+OFF_W-1:0]   lk_vaddr,
  input  logic                     fill_valid,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic [FRAME_W-1:0]       fill_frame,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic [FRAME_W-1:0]       res_paddr
);
  localparam int RANK_W = $clog2(LINES);
  localparam int VA_W   = TAG_W + OFF_W;

  logic [TAG_W-1:0]         look_tag;
  logic [OFF_W-1:0]         look_off;
  logic [LINES-1:0]         match;
  logic [LINES-1:0]         victim;
  logic [LINES-1:0]         chosen;
  logic [LINES-1:0]         valid_vec;
  logic [LINES*RANK_W-1:0]  rank_flat;
  logic [LINES*FRAME_W-1:0] frame_flat;
  logic                     any_hit;
  logic [RANK_W-1:0]        hit_rank;
  logic [RANK_W-1:0]        ref_rank;
  logic [FRAME_W-1:0]       hit_frame;
  upd_e                     upd;

  assign look_tag = lk_vaddr[VA_W-1:OFF_W];
  assign look_off = lk_vaddr[OFF_W-1:0];

  always_comb begin
    if (fill_valid) begin
      upd      = UPD_FILL;
      chosen   = victim;
      ref_rank = '0;
    end else if (lk_valid && any_hit) begin
      upd      = UPD_HIT;
      chosen   = match;
      ref_rank = hit_rank;
    end else begin
      upd      = UPD_NONE;
      chosen   = '0;
      ref_rank = '0;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    xlat_line #(
      .TAG_W(TAG_W), .FRAME_W(FRAME_W), .RANK_W(RANK_W), .INIT_RANK(i)
    ) u_line (
      .clk       (clk),
      .rst       (rst),
      .upd       (upd),
      .chosen    (chosen[i]),
      .ref_rank  (ref_rank),
      .fill_tag  (fill_tag),
      .fill_frame(fill_frame),
      .look_tag  (look_tag),
      .match     (match[i]),
      .frame     (frame_flat[i*FRAME_W +: FRAME_W]),
      .rank      (rank_flat[i*RANK_W +: RANK_W]),
      .valid     (valid_vec[i])
    );
  end

  xlat_pick #(.LINES(LINES), .RANK_W(RANK_W), .FRAME_W(FRAME_W)) u_pick (
    .match     (match),
    .rank_flat (rank_flat),
    .frame_flat(frame_flat),
    .any_hit   (any_hit),
    .hit_rank  (hit_rank),
    .hit_frame (hit_frame),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_hit;
      res_paddr <= (lk_valid && any_hit) ? hit_frame + FRAME_W'(look_off) : '0;
    end
  end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int LINES   = 4,
  parameter int RANK_W  = 2,
  parameter int FRAME_W = 19
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    lk_valid,
  input logic                    fill_valid,
  input logic                    res_valid,
  input logic                    res_hit,
  input logic [FRAME_W-1:0]      res_paddr,
  input logic [LINES*RANK_W-1:0] rank_flat,
  input logic [LINES-1:0]        valid_vec
);
  logic [LINES-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < LINES; i++) seen[rank_flat[i*RANK_W +: RANK_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_RANK_PERM: assert (seen == '1); // R7
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !res_hit)); // R1
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_vec == '0)); // R1
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (valid_vec != '0)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_paddr == '0)); // R4
  AST_MISS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> $stable(rank_flat)); // R4
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (valid_vec != '0)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && fill_valid)); // R8
endmodule

bind xlat_cache xlat_chk #(.LINES(LINES), .RANK_W(RANK_W), .FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .fill_valid(fill_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_paddr (res_paddr),
  .rank_flat (rank_flat),
  .valid_vec (valid_vec)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
  localparam int LINES = 4, TAG_W = 19, OFF_W = 9, FRAME_W = 19;
  localparam int PMASK = (1 << FRAME_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [TAG_W+OFF_W-1:0] lk_vaddr = '0;
  logic fill_valid = 1'b0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [FRAME_W-1:0] fill_frame = '0;
  logic res_valid, res_hit;
  logic [FRAME_W-1:0] res_paddr;

  int total = 0, fails = 0;
  bit done = 0;
  int m_rank[LINES], m_tag[LINES], m_frame[LINES];
  bit m_val[LINES];
  int seed = 32'h1234567;

  always #2 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_frame(fill_frame),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) begin
      m_rank[i] = i; m_val[i] = 0; m_tag[i] = 0; m_frame[i] = 0;
    end
  endtask

  // lookup; returns model's hit flag
  task automatic lookup(input int tag, input int off, input string req, output bit hit);
    int k = -1;
    int exp_pa = 0;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {TAG_W'(tag), OFF_W'(off)};
    for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == tag) k = i;
    hit = (k >= 0);
    if (hit) begin
      int r = m_rank[k];
      exp_pa = (m_frame[k] + off) & PMASK;
      for (int j = 0; j < LINES; j++) if (m_rank[j] > r) m_rank[j]--;
      m_rank[k] = LINES - 1;
    end
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid == 1'b1, {req, " R2 res_valid"}, res_valid, 1);
    chk(res_hit == hit, {req, " hit flag"}, res_hit, hit);
    chk(res_paddr == FRAME_W'(exp_pa), {req, " paddr"}, res_paddr, exp_pa);
  endtask

  task automatic fill(input int tag, input int frame);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_tag = TAG_W'(tag);
    fill_frame = FRAME_W'(frame);
    for (int i = 0; i < LINES; i++) begin
      if (m_rank[i] == 0) begin
        m_rank[i] = LINES - 1; m_val[i] = 1; m_tag[i] = tag; m_frame[i] = frame;
      end else m_rank[i]--;
    end
    @(negedge clk);
    fill_valid = 1'b0;
    chk(res_valid == 1'b0, "R2 no result after fill", res_valid, 0);
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fffff;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit h;
    model_reset();
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    chk(res_hit == 1'b0, "R1 res_hit in reset", res_hit, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    // R1: empty cache misses even on tag 0
    lookup(0, 5, "R1 empty lookup", h);
    lookup(19'h100, 0, "R4 miss", h);
    // R9/R5: four fills go to lines in reset rank order
    fill(19'h100, 19'h00200);
    fill(19'h101, 19'h00400);
    fill(19'h102, 19'h7FF00);
    fill(19'h103, 19'h01000);
    // R3: hits with offset edges, including wrap
    lookup(19'h100, 0, "R3 hit off0", h);
    lookup(19'h102, 511, "R3 hit wrap", h);
    lookup(19'h103, 7, "R3 hit mid", h);
    // R6: reorder then fill evicts least recent (0x101)
    fill(19'h104, 19'h02000);
    lookup(19'h101, 3, "R6 evicted line", h);
    lookup(19'h100, 9, "R6 kept line", h);
    // R4: misses do not disturb replacement
    lookup(19'h1FF, 1, "R4 miss no change", h);
    lookup(19'h1FE, 2, "R4 miss no change", h);
    fill(19'h105, 19'h03000);
    lookup(19'h102, 1, "R7 victim order", h);
    lookup(19'h105, 4, "R5 new line hit", h);
    // R7: pseudo-random stress over a pool larger than the cache
    for (int it = 0; it < 400; it++) begin
      int t = 19'h200 + (rnd() % 6);
      int o = rnd() % 512;
      lookup(t, o, "R7 stress", h);
      if (!h && (rnd() % 4 != 0)) fill(t, (t * 1531 + it * 512) & PMASK);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule